// File: doc/BRIEF.md
# Dual-Mode Stack Pointer and Operand Width Controller

This block holds the stack pointer and the operating mode of a CPU core that stays byte-compatible with an older 8-bit design but also has a 16-bit extension. It leaves reset in the compatibility (emulation) mode. In that mode the stack is confined to page one and every operand is 8 bits wide. A software mode-write command moves it into native mode. There the stack pointer spans the full 64K space, and the accumulator, the index registers and memory operands can each be made 16 bits wide.

For every push or pop the block drives the stack address, a write or read byte strobe and a high/low byte select. A 16-bit memory operand is moved as two consecutive byte accesses, and a busy flag holds off new requests during the second one. The core's decoder issues one request per cycle at most. When several request inputs are high together, the block takes only the highest-priority one.

Top module: `stack_mode_ctrl`

## Requirements
- R1: After reset the block is in emulation mode (`native_o`=0), the stack pointer is 0x01FF, all three width flags are 0 (8-bit) and `busy_o` is 0.
- R2: In emulation mode the stack pointer high byte always reads 0x01. An emulation-mode load of value V sets the pointer to {0x01, V[7:0]}.
- R3: In native mode a load sets all 16 bits of the stack pointer. Pushes and pops carry and borrow across the full 16 bits and wrap at 0x0000/0xFFFF.
- R4: The mode changes only on an accepted mode write (`native_o` takes `mode_native_i`). A mode write to emulation sets the pointer high byte to 0x01 and clears all three width flags at the same clock edge.
- R5: In native mode an accepted width write loads `acc_wide_o`, `idx_wide_o` and `mem_wide_o` from their inputs, where 1 means 16 bits. In emulation mode a width write is ignored and the flags stay 0.
- R6: An accepted push drives `stack_addr_o` = SP with `byte_we_o`=1, and SP then decrements. An accepted pop drives `stack_addr_o` = SP+1 with `byte_re_o`=1, and SP then increments. In emulation mode the low byte wraps within page one.
- R7: With `mem_wide_o`=1, a push takes two cycles. The first writes the high byte (`byte_hi_o`=1) at SP and the second writes the low byte (`byte_hi_o`=0) at SP-1. A wide pop reads the low byte at SP+1 and then the high byte at SP+2. With `mem_wide_o`=0, `byte_hi_o` is 0.
- R8: `busy_o` is 1 for exactly the second cycle of a wide transfer. All request inputs are ignored while it is 1.
- R9: When `busy_o` is 0, only one request is accepted per cycle. The priority order is mode write, width write, stack load, push, pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Mode write request |
| mode_native_i | input | 1 | Mode to write: 1 = native, 0 = emulation |
| width_wr_i | input | 1 | Width flag write request |
| acc_wide_i | input | 1 | New accumulator width (1 = 16-bit) |
| idx_wide_i | input | 1 | New index register width (1 = 16-bit) |
| mem_wide_i | input | 1 | New memory operand width (1 = 16-bit) |
| sp_load_i | input | 1 | Stack pointer load request |
| sp_load_val_i | input | 16 | Value to load into the stack pointer |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| stack_addr_o | output | 16 | Address of the current stack byte access |
| byte_we_o | output | 1 | Stack byte write strobe |
| byte_re_o | output | 1 | Stack byte read strobe |
| byte_hi_o | output | 1 | 1 = the access carries the high operand byte |
| busy_o | output | 1 | Second byte of a wide transfer is in progress |
| native_o | output | 1 | 1 = native mode |
| acc_wide_o | output | 1 | Current accumulator width |
| idx_wide_o | output | 1 | Current index register width |
| mem_wide_o | output | 1 | Current memory operand width |
| sp_o | output | 16 | Current stack pointer |

## Verification
Directed sequences start with page-one wraparound in emulation mode, where a pop from 0x01FF reads 0x0100 and a push from 0x0100 returns the pointer to 0x01FF. These show whether the high byte is truly pinned or just loaded once. Native pushes and pops across 0x0000 and 0xFFFF then confirm that carries reach the high byte. Wide pushes and pops confirm the byte order across the two cycles.

Constrained-random runs mix requests, often several at once and often during busy cycles. This exposes mistakes in priority and in request blocking. Occasional mode writes in both directions test that mode exit clears the widths and the page.

// File: rtl/stack_mode_ctrl.sv
module stack_mode_ctrl #(
  parameter logic [15:0] SP_RESET = 16'h01FF,
  parameter logic [7:0]  EMU_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr_i,
  input  logic        mode_native_i,
  input  logic        width_wr_i,
  input  logic        acc_wide_i,
  input  logic        idx_wide_i,
  input  logic        mem_wide_i,
  input  logic        sp_load_i,
  input  logic [15:0] sp_load_val_i,
  input  logic        push_i,
  input  logic        pop_i,
  output logic [15:0] stack_addr_o,
  output logic        byte_we_o,
  output logic        byte_re_o,
  output logic        byte_hi_o,
  output logic        busy_o,
  output logic        native_o,
  output logic        acc_wide_o,
  output logic        idx_wide_o,
  output logic        mem_wide_o,
  output logic [15:0] sp_o
);

  logic        native_q, acc_q, idx_q, mem_q, busy_q, dir_push_q;
  logic [15:0] sp_q;

  wire idle     = !busy_q;
  wire do_mode  = idle & mode_wr_i;
  wire do_width = idle & !mode_wr_i & width_wr_i;
  wire do_load  = idle & !mode_wr_i & !width_wr_i & sp_load_i;
  wire do_push  = idle & !mode_wr_i & !width_wr_i & !sp_load_i & push_i;
  wire do_pop   = idle & !mode_wr_i & !width_wr_i & !sp_load_i & !push_i & pop_i;

  wire push_now = do_push | (busy_q & dir_push_q);
  wire pop_now  = do_pop  | (busy_q & !dir_push_q);

  wire [15:0] sp_dec_raw = sp_q - 16'd1;
  wire [15:0] sp_inc_raw = sp_q + 16'd1;
  wire [15:0] sp_dec  = native_q ? sp_dec_raw : {EMU_PAGE, sp_dec_raw[7:0]};
  wire [15:0] sp_inc  = native_q ? sp_inc_raw : {EMU_PAGE, sp_inc_raw[7:0]};
  wire [15:0] sp_ld   = native_q ? sp_load_val_i : {EMU_PAGE, sp_load_val_i[7:0]};

  assign stack_addr_o = pop_now ? sp_inc : sp_q;
  assign byte_we_o    = push_now;
  assign byte_re_o    = pop_now;
  assign byte_hi_o    = do_push ? mem_q : (busy_q & !dir_push_q);
  assign busy_o       = busy_q;
  assign native_o     = native_q;
  assign acc_wide_o   = acc_q;
  assign idx_wide_o   = idx_q;
  assign mem_wide_o   = mem_q;
  assign sp_o         = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      native_q   <= 1'b0;
      acc_q      <= 1'b0;
      idx_q      <= 1'b0;
      mem_q      <= 1'b0;
      busy_q     <= 1'b0;
      dir_push_q <= 1'b0;
      sp_q       <= SP_RESET;
    end else begin
      busy_q <= (do_push | do_pop) & mem_q;
      if (do_push | do_pop) dir_push_q <= do_push;
      if (push_now) sp_q <= sp_dec;
      if (pop_now)  sp_q <= sp_inc;
      if (do_load)  sp_q <= sp_ld;
      if (do_mode) begin
        native_q <= mode_native_i;
        if (!mode_native_i) begin
          sp_q[15:8] <= EMU_PAGE;
          acc_q <= 1'b0;
          idx_q <= 1'b0;
          mem_q <= 1'b0;
        end
      end
      if (do_width && native_q) begin
        acc_q <= acc_wide_i;
        idx_q <= idx_wide_i;
        mem_q <= mem_wide_i;
      end
    end
  end

  // R2
  emu_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !native_o |-> sp_o[15:8] == EMU_PAGE);

  // R5
  emu_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !native_o |-> !acc_wide_o && !idx_wide_o && !mem_wide_o);

  // R8
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);

  // R7
  wide_push_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we_o && !busy_o && byte_hi_o |=> busy_o && byte_we_o && !byte_hi_o);

  // R4
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && mode_wr_i && !mode_native_i |=>
      !native_o && sp_o[15:8] == EMU_PAGE && !acc_wide_o && !idx_wide_o && !mem_wide_o);

  // R3
  native_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    native_o && byte_we_o |=> sp_o == $past(sp_o) - 16'd1);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_we_o && byte_re_o));

endmodule

// File: tb/tb_stack_mode_ctrl.sv
module tb_stack_mode_ctrl;
  logic clk = 0, rst_n = 0;
  logic mode_wr_i = 0, mode_native_i = 0, width_wr_i = 0;
  logic acc_wide_i = 0, idx_wide_i = 0, mem_wide_i = 0;
  logic sp_load_i = 0, push_i = 0, pop_i = 0;
  logic [15:0] sp_load_val_i = 0;
  logic [15:0] stack_addr_o, sp_o;
  logic byte_we_o, byte_re_o, byte_hi_o, busy_o, native_o, acc_wide_o, idx_wide_o, mem_wide_o;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic m_nat, m_acc, m_idx, m_mem, m_busy, m_dpush;
  logic [15:0] m_sp;

  always #5 clk = ~clk;

  stack_mode_ctrl dut (.*);

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired: actual hung, expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wrap(logic nat, logic [15:0] v);
    return nat ? v : {8'h01, v[7:0]};
  endfunction

  // compare outputs with model for the current inputs, then advance model
  task automatic step();
    logic idle, dm, dw, dl, dp, dq, pn, qn;
    logic [15:0] ea;
    #1;
    idle = !m_busy;
    dm = idle & mode_wr_i;
    dw = idle & !mode_wr_i & width_wr_i;
    dl = idle & !mode_wr_i & !width_wr_i & sp_load_i;
    dp = idle & !mode_wr_i & !width_wr_i & !sp_load_i & push_i;
    dq = idle & !mode_wr_i & !width_wr_i & !sp_load_i & !push_i & pop_i;
    pn = dp | (m_busy & m_dpush);
    qn = dq | (m_busy & !m_dpush);
    ea = qn ? wrap(m_nat, m_sp + 16'd1) : m_sp;
    chk("R6 we", 16'(byte_we_o), 16'(pn));
    chk("R6 re", 16'(byte_re_o), 16'(qn));
    if (pn | qn) chk("R6 addr", stack_addr_o, ea);
    if (pn | qn) chk("R7 hi", 16'(byte_hi_o), 16'(dp ? m_mem : (m_busy & !m_dpush)));
    chk("R8 busy", 16'(busy_o), 16'(m_busy));
    chk("R3 sp", sp_o, m_sp);
    chk("R4 mode", 16'(native_o), 16'(m_nat));
    chk("R5 widths", {13'd0, acc_wide_o, idx_wide_o, mem_wide_o}, {13'd0, m_acc, m_idx, m_mem});
    // R9 priority and R8 blocking reflected in next state
    m_busy = (dp | dq) & m_mem;
    if (dp | dq) m_dpush = dp;
    if (pn) m_sp = wrap(m_nat, m_sp - 16'd1);
    if (qn) m_sp = wrap(m_nat, m_sp + 16'd1);
    if (dl) m_sp = wrap(m_nat, sp_load_val_i);
    if (dw && m_nat) begin m_acc = acc_wide_i; m_idx = idx_wide_i; m_mem = mem_wide_i; end
    if (dm) begin
      m_nat = mode_native_i;
      if (!mode_native_i) begin m_sp[15:8] = 8'h01; m_acc = 0; m_idx = 0; m_mem = 0; end
    end
    @(negedge clk);
  endtask

  task automatic clr();
    mode_wr_i = 0; width_wr_i = 0; sp_load_i = 0; push_i = 0; pop_i = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    m_nat = 0; m_acc = 0; m_idx = 0; m_mem = 0; m_busy = 0; m_dpush = 0; m_sp = 16'h01FF;
    #23; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", sp_o, 16'h01FF);
    chk("R1 native", 16'(native_o), 16'd0);
    chk("R1 busy", 16'(busy_o), 16'd0);
    // R6 emulation pop wraps to 0x0100
    pop_i = 1; step(); clr();
    chk("R6 pop wrap", sp_o, 16'h0100);
    push_i = 1; step(); clr();
    chk("R6 push wrap", sp_o, 16'h01FF);
    // R2 emulation load forces page one
    sp_load_i = 1; sp_load_val_i = 16'hABCD; step(); clr();
    chk("R2 load", sp_o, 16'h01CD);
    // R5 width write ignored in emulation
    width_wr_i = 1; acc_wide_i = 1; idx_wide_i = 1; mem_wide_i = 1; step(); clr();
    chk("R5 ignored", {13'd0, acc_wide_o, idx_wide_o, mem_wide_o}, 16'd0);
    // R4 enter native, R3 full-range load and wrap at zero
    mode_wr_i = 1; mode_native_i = 1; step(); clr();
    sp_load_i = 1; sp_load_val_i = 16'h0000; step(); clr();
    push_i = 1; step(); clr();
    chk("R3 borrow", sp_o, 16'hFFFF);
    pop_i = 1; step(); clr();
    chk("R3 carry", sp_o, 16'h0000);
    // R7 wide push then pop, with requests during busy (R8)
    width_wr_i = 1; acc_wide_i = 1; idx_wide_i = 0; mem_wide_i = 1; step(); clr();
    sp_load_i = 1; sp_load_val_i = 16'h3000; step(); clr();
    push_i = 1; step(); pop_i = 1; step(); clr();
    chk("R7 wide push sp", sp_o, 16'h2FFE);
    pop_i = 1; step(); push_i = 1; step(); clr();
    chk("R7 wide pop sp", sp_o, 16'h3000);
    // R9 all requests at once: mode write wins
    mode_wr_i = 1; mode_native_i = 0; width_wr_i = 1; sp_load_i = 1; push_i = 1; pop_i = 1;
    step(); clr();
    chk("R4 exit", {sp_o[15:8], 7'd0, native_o}, 16'h0100);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      mode_wr_i = (r < 3);
      mode_native_i = $urandom_range(0, 3) != 0;
      width_wr_i = $urandom_range(0, 99) < 6;
      acc_wide_i = $urandom_range(0, 1);
      idx_wide_i = $urandom_range(0, 1);
      mem_wide_i = $urandom_range(0, 1);
      sp_load_i = $urandom_range(0, 99) < 5;
      sp_load_val_i = 16'($urandom);
      push_i = $urandom_range(0, 99) < 40;
      pop_i = $urandom_range(0, 99) < 40;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule